// File: doc/BRIEF.md
# Long-Word to Byte/Word Bus Unpacker

This block sits between the read side of a 36-bit first-word-fall-through FIFO and a narrow output port. Each 36-bit long word is made of four 9-bit bytes. A static swap select rearranges whole bytes inside the long word. The rearranged word is then handed out one piece per read, either as 9-bit bytes or as 18-bit words. A static size select picks between the two. Pieces leave most significant first.

The first read of a long word pops it from the FIFO. That read places the first piece in the output register and keeps the rest of the word in an auxiliary register. The later reads take their pieces from that register. The availability output stays high until the final piece of the last stored long word has been read. Size and swap selects are meant to be changed only while reset is held.

Top module: `lw_unpacker`

## Requirements
- R1: A synchronous active-low reset clears the output register to zero and discards any partly consumed long word. Right after reset, `dout_avail` is low while the source is empty and no pop is issued.
- R2: The swap select acts on the long word, written as bytes {b3,b2,b1,b0} with b3 at bits 35:27. The encodings are:
  - 2'b00 keeps {b3,b2,b1,b0}.
  - 2'b01 gives {b0,b1,b2,b3}.
  - 2'b10 gives {b1,b0,b3,b2}.
  - 2'b11 gives {b2,b3,b0,b1}.
  Swapping never alters bits inside a byte.
- R3: `size_sel` 2'b01 selects byte mode and 2'b10 selects word mode. The values 2'b00 and 2'b11 are reserved and must not be applied.
- R4: In byte mode, four accepted reads show the swapped bytes on `dout[8:0]`, from bits 35:27 down to bits 8:0. Each byte becomes visible after the clock edge of its read.
- R5: In word mode, two accepted reads show the swapped long word's bits 35:18 and then bits 17:0 on `dout[17:0]`.
- R6: In byte mode, `dout[17:9]` never changes.
- R7: `src_pop` is high only in the cycle of an accepted read that takes the first piece of a long word, so it pops exactly once per long word. It is never high while `src_valid` is low.
- R8: `dout_avail` stays high while pieces of the current long word remain, even when the source is empty. It drops after the final piece when no further long word is waiting.
- R9: A read requested while `dout_avail` is low is ignored: `dout` keeps its value and no pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 2 | Static bus size select (01 byte, 10 word) |
| swap_sel | input | 2 | Static byte arrangement select |
| src_data | input | 36 | Head long word of the source FIFO |
| src_valid | input | 1 | Source FIFO holds at least one long word |
| src_pop | output | 1 | Removes the head long word from the source |
| rd_en | input | 1 | Read request from the narrow side |
| dout | output | 18 | Output register |
| dout_avail | output | 1 | A piece is ready to be read |

## Verification
The assertions assume that `size_sel` holds one of its two legal codes and stays constant while reset is released. They also assume the source shows a valid word on `src_data` whenever `src_valid` is high. The stimulus sets size and swap only while reset is held. It sweeps all eight legal combinations, and each combination begins with a fresh reset. A bench-side source queue models a fall-through FIFO that drops its head only on `src_pop`. Random reads and pushes are mixed with a directed long word and with reads issued while nothing is available.

// File: rtl/lwu_pkg.sv
// Package: shared encodings for the long-word unpacker.
// Assumes: size and swap codes are static between resets.
package lwu_pkg;

    typedef enum logic [1:0] {
        SWAP_KEEP = 2'b00,
        SWAP_REV  = 2'b01,
        SWAP_HALF = 2'b10,
        SWAP_PAIR = 2'b11
    } swap_mode_e;

    localparam logic [1:0] SIZE_BYTE = 2'b01;
    localparam logic [1:0] SIZE_WORD = 2'b10;

endpackage

// File: rtl/lwu_byte_swap.sv
// Module: lwu_byte_swap
// Rearranges whole bytes of a long word according to the swap mode.
// Assumes: LANES is even; the mode is static while data flows.
module lwu_byte_swap #(
    parameter int BYTE_W = 9,
    parameter int LANES  = 4
) (
    input  logic [1:0]              swap_sel,
    input  logic [BYTE_W*LANES-1:0] din,
    output logic [BYTE_W*LANES-1:0] dout
);
    import lwu_pkg::*;

    localparam int HALF = LANES / 2;

    swap_mode_e mode;
    assign mode = swap_mode_e'(swap_sel);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int SRC_REV  = LANES - 1 - g;
        localparam int SRC_HALF = (g + HALF) % LANES;
        localparam int SRC_PAIR = (g / HALF) * HALF + (HALF - 1 - (g % HALF));

        // Pick the source byte for this output lane.
        always_comb begin
            unique case (mode)
                SWAP_REV:  dout[g*BYTE_W +: BYTE_W] = din[SRC_REV*BYTE_W  +: BYTE_W];
                SWAP_HALF: dout[g*BYTE_W +: BYTE_W] = din[SRC_HALF*BYTE_W +: BYTE_W];
                SWAP_PAIR: dout[g*BYTE_W +: BYTE_W] = din[SRC_PAIR*BYTE_W +: BYTE_W];
                default:   dout[g*BYTE_W +: BYTE_W] = din[g*BYTE_W        +: BYTE_W];
            endcase
        end
    end

endmodule

// File: rtl/lwu_piece_seq.sv
// Module: lwu_piece_seq
// Counts pieces of the current long word and decides when to pop the source.
// Assumes: byte_mode is static between resets; the source is fall-through.
module lwu_piece_seq #(
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             rd_en,
    input  logic             src_valid,
    output logic             fire,
    output logic             first,
    output logic [IDX_W-1:0] piece_idx,
    output logic             avail,
    output logic             src_pop
);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(LANES - 1);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(LANES / 2 - 1);

    logic [IDX_W-1:0] idx_q;
    logic             last;

    // Decode the piece position and the handshake of this cycle.
    always_comb begin
        first   = (idx_q == '0);
        last    = byte_mode ? (idx_q == LAST_BYTE) : (idx_q == LAST_WORD);
        avail   = !first || src_valid;
        fire    = rd_en && avail;
        src_pop = fire && first;
    end

    // Advance the piece counter on each accepted read and wrap after the last piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

    assign piece_idx = idx_q;

endmodule

// File: rtl/lwu_piece_out.sv
// Module: lwu_piece_out
// Holds the swapped long word and loads the selected piece into the output register.
// Assumes: piece_idx stays within the piece count of the active mode.
module lwu_piece_out #(
    parameter int BYTE_W = 9,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES),
    localparam int LW_W  = BYTE_W * LANES,
    localparam int OUT_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             fire,
    input  logic             first,
    input  logic [IDX_W-1:0] piece_idx,
    input  logic [LW_W-1:0]  swapped,
    output logic [OUT_W-1:0] dout
);
    logic [LW_W-1:0]   hold_q;
    logic [LW_W-1:0]   src_w;
    logic [BYTE_W-1:0] lane [LANES];
    logic [BYTE_W-1:0] byte_pick;
    logic [OUT_W-1:0]  word_pick;
    logic [OUT_W-1:0]  dout_q;

    // A fresh long word is used directly; later pieces come from the holding register.
    assign src_w = first ? swapped : hold_q;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane[g] = src_w[g*BYTE_W +: BYTE_W];
    end

    // Choose the byte and the word addressed by the piece counter, most significant first.
    always_comb begin
        byte_pick = '0;
        word_pick = '0;
        for (int k = 0; k < LANES; k++) begin
            if (piece_idx == IDX_W'(k)) byte_pick = lane[LANES-1-k];
        end
        for (int k = 0; k < LANES / 2; k++) begin
            if (piece_idx == IDX_W'(k)) word_pick = {lane[LANES-1-2*k], lane[LANES-2-2*k]};
        end
    end

    // Capture the remainder of a new long word and update the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            dout_q <= '0;
        end else if (fire) begin
            if (first) hold_q <= swapped;
            if (byte_mode) dout_q[BYTE_W-1:0] <= byte_pick;
            else           dout_q             <= word_pick;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/lw_unpacker.sv
// Module: lw_unpacker (top)
// Unpacks swapped long words from a fall-through FIFO into byte or word pieces.
// Assumes: size_sel is 01 or 10; size_sel and swap_sel change only under reset.
module lw_unpacker #(
    parameter int BYTE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                size_sel,
    input  logic [1:0]                swap_sel,
    input  logic [BYTE_W*LANES-1:0]   src_data,
    input  logic                      src_valid,
    output logic                      src_pop,
    input  logic                      rd_en,
    output logic [2*BYTE_W-1:0]       dout,
    output logic                      dout_avail
);
    import lwu_pkg::*;

    localparam int IDX_W = $clog2(LANES);
    localparam int LW_W  = BYTE_W * LANES;

    logic             byte_mode;
    logic             fire;
    logic             first;
    logic [IDX_W-1:0] piece_idx;
    logic [LW_W-1:0]  swapped;

    // Decode the static bus size.
    assign byte_mode = (size_sel == SIZE_BYTE);

    lwu_byte_swap #(.BYTE_W(BYTE_W), .LANES(LANES)) u_swap (
        .swap_sel (swap_sel),
        .din      (src_data),
        .dout     (swapped)
    );

    lwu_piece_seq #(.LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .rd_en     (rd_en),
        .src_valid (src_valid),
        .fire      (fire),
        .first     (first),
        .piece_idx (piece_idx),
        .avail     (dout_avail),
        .src_pop   (src_pop)
    );

    lwu_piece_out #(.BYTE_W(BYTE_W), .LANES(LANES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .fire      (fire),
        .first     (first),
        .piece_idx (piece_idx),
        .swapped   (swapped),
        .dout      (dout)
    );

endmodule

// File: rtl/lw_unpacker_chk.sv
// Module: lw_unpacker_chk
// Checker bound to lw_unpacker; watches ports and the piece counter.
// Assumes: reset is low from time zero.
module lw_unpacker_chk #(
    parameter int BYTE_W = 9,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES),
    localparam int OUT_W = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       size_sel,
    input logic             src_valid,
    input logic             src_pop,
    input logic             rd_en,
    input logic [OUT_W-1:0] dout,
    input logic             dout_avail,
    input logic [IDX_W-1:0] piece_idx
);
    // R3
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'b01) || (size_sel == 2'b10));

    // R3
    size_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(size_sel));

    // R7
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (src_valid && rd_en && dout_avail));

    // R7
    pop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |=> (piece_idx == IDX_W'(1)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && dout_avail) |=> $stable(dout));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'b01) |=> $stable(dout[OUT_W-1:BYTE_W]));

    // R8
    pending_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_idx != '0) |-> dout_avail);

    // R5
    word_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'b10) |-> (piece_idx < IDX_W'(LANES / 2)));

endmodule

bind lw_unpacker lw_unpacker_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_sel   (size_sel),
    .src_valid  (src_valid),
    .src_pop    (src_pop),
    .rd_en      (rd_en),
    .dout       (dout),
    .dout_avail (dout_avail),
    .piece_idx  (piece_idx)
);

// File: tb/tb_lw_unpacker.sv
module tb_lw_unpacker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  size_sel = 2'b01;
    logic [1:0]  swap_sel = 2'b00;
    logic [35:0] src_data = '0;
    logic        src_valid = 1'b0;
    logic        src_pop;
    logic        rd_en = 1'b0;
    logic [17:0] dout;
    logic        dout_avail;

    int checks = 0;
    int fails  = 0;

    logic [35:0] sq [$];
    logic [17:0] pq [$];
    bit          pf [$];
    logic [17:0] exp_dout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lw_unpacker dut (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .swap_sel(swap_sel),
        .src_data(src_data), .src_valid(src_valid), .src_pop(src_pop),
        .rd_en(rd_en), .dout(dout), .dout_avail(dout_avail)
    );

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Byte arrangement per R2
    function automatic logic [35:0] f_swap(input logic [35:0] w, input logic [1:0] m);
        logic [8:0] b3, b2, b1, b0;
        {b3, b2, b1, b0} = w;
        case (m)
            2'b01:   return {b0, b1, b2, b3};
            2'b10:   return {b1, b0, b3, b2};
            2'b11:   return {b2, b3, b0, b1};
            default: return {b3, b2, b1, b0};
        endcase
    endfunction

    function automatic void refresh();
        src_valid = (sq.size() != 0);
        src_data  = src_valid ? sq[0] : 36'h0;
    endfunction

    function automatic void push_word(input logic [35:0] w);
        logic [35:0] s;
        s = f_swap(w, swap_sel);
        sq.push_back(w);
        if (size_sel == 2'b01) begin
            for (int k = 0; k < 4; k++) begin
                pq.push_back({9'h0, s[35-9*k -: 9]});
                pf.push_back(k == 0);
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                pq.push_back(s[35-18*k -: 18]);
                pf.push_back(k == 0);
            end
        end
        refresh();
    endfunction

    task automatic do_reset(input logic [1:0] sz, input logic [1:0] sw);
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 1'b0;
        size_sel = sz;
        swap_sel = sw;
        sq.delete(); pq.delete(); pf.delete();
        refresh();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_dout = '0;
        #1;
        // R1 reset state
        chk(dout == 18'h0, "R1 dout after reset", 36'(dout), 36'h0);
        chk(dout_avail == 1'b0, "R1 avail after reset", 36'(dout_avail), 36'h0);
        chk(src_pop == 1'b0, "R1 no pop after reset", 36'(src_pop), 36'h0);
    endtask

    // One cycle: starts just after a falling edge, ends just after the next falling edge.
    task automatic step(input bit rd, input bit push, input logic [35:0] w);
        bit ex_av, ex_pop, acc;
        if (push) push_word(w);
        rd_en = rd;
        #1;
        ex_av  = (pq.size() != 0);
        ex_pop = rd && ex_av && pf[0];
        acc    = rd && ex_av;
        chk(dout_avail == ex_av, "R8 dout_avail", 36'(dout_avail), 36'(ex_av));
        chk(src_pop == ex_pop, acc ? "R7 src_pop" : "R9 src_pop on idle read", 36'(src_pop), 36'(ex_pop));
        @(posedge clk);
        #1;
        if (ex_pop) void'(sq.pop_front());
        refresh();
        if (acc) begin
            logic [17:0] p;
            p = pq.pop_front();
            void'(pf.pop_front());
            if (size_sel == 2'b01) exp_dout[8:0] = p[8:0];
            else                   exp_dout      = p;
        end
        @(negedge clk);
        if (!acc)                   chk(dout == exp_dout, "R9 dout held", 36'(dout), 36'(exp_dout));
        else if (size_sel == 2'b01) chk(dout == exp_dout, "R2 R4 byte piece", 36'(dout), 36'(exp_dout));
        else                        chk(dout == exp_dout, "R2 R5 word piece", 36'(dout), 36'(exp_dout));
        if (size_sel == 2'b01)
            chk(dout[17:9] == exp_dout[17:9], "R6 upper bits held", 36'(dout[17:9]), 36'(exp_dout[17:9]));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int sz = 0; sz < 2; sz++) begin
            for (int sw = 0; sw < 4; sw++) begin
                // R3 legal size codes only
                do_reset(sz == 0 ? 2'b01 : 2'b10, 2'(sw));
                step(1'b1, 1'b0, 36'h0);                       // R9 read while empty
                step(1'b0, 1'b1, {9'h1A3, 9'h0F5, 9'h156, 9'h08C});
                for (int k = 0; k < (sz == 0 ? 4 : 2); k++)
                    step(1'b1, 1'b0, 36'h0);                   // R8 pieces drain, source empty
                step(1'b1, 1'b0, 36'h0);                       // R9 after last piece
                for (int c = 0; c < 80; c++) begin
                    bit rd, ps;
                    rd = ($urandom % 4) != 0;
                    ps = (sq.size() < 6) && (($urandom % 3) == 0);
                    step(rd, ps, {$urandom, $urandom} & 36'hF_FFFF_FFFF);
                end
                for (int c = 0; c < 30; c++) step(1'b1, 1'b0, 36'h0);
            end
        end
        disable watchdog;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule